// File: doc/BRIEF.md
# SPI Debug Control Unit

This block is the command front end of an on-chip logic analyser. A host acts as SPI master and sends framed commands. Each command is an opcode byte, followed by a payload when the opcode needs one. The unit uses these commands to:

- load the trigger comparison value, the care mask and the single-bit edge trigger;
- pulse arm and stop strobes to the capture controller;
- report the capture controller's status;
- stream words out of the capture buffer.

The unit also owns a hold-in-reset line for the design under observation. The host can hold that design in reset before a capture. The hold drops in the same clock cycle that the arm strobe fires, so the first samples are the design's first cycles out of reset. The device's own post-configuration reset still acts on the line, whatever the hold does.

All three SPI pins come in through two-flop synchronisers into the system clock. Bits are taken on the detected rising edge of the serial clock.

The control state machine has seven states:

- `ST_OPC` waits for an opcode.
- `ST_PAT` collects the trigger value payload.
- `ST_MSK` collects the mask payload.
- `ST_EDGE` takes one edge-select byte.
- `ST_STAT` shifts out one status byte.
- `ST_READ` streams buffer words.
- `ST_SKIP` discards bytes after an unknown opcode.

Its transitions are:

- From `ST_OPC`, an opcode byte leads to the matching state. A single-byte command (hold on, hold off, arm, stop) stays in `ST_OPC`. An unknown opcode leads to `ST_SKIP`.
- `ST_PAT` and `ST_MSK` return to `ST_OPC` on their last payload byte.
- `ST_EDGE` and `ST_STAT` return to `ST_OPC` after one byte.
- `ST_READ` and `ST_SKIP` stay where they are.
- In every state, a rising chip select forces a return to `ST_OPC`.

Top module: `spi_dbg_ctrl`

## Requirements
- R1: The link is SPI mode 0, most significant bit first. A byte is complete on the eighth sampled rising clock edge while chip select is low, and the first byte of each frame is an opcode.
- R2: Opcode 0x01 is followed by VEC_W/8 bytes, most significant byte first. `trig_pattern` takes the assembled value once the last byte arrives.
- R3: Opcode 0x02 is followed by VEC_W/8 bytes, most significant byte first. `trig_mask` takes the assembled value once the last byte arrives.
- R4: Opcode 0x03 is followed by one byte. Bit 7 sets `trig_edge_en`, bit 6 sets `trig_edge_rise` (1 selects rising, 0 selects falling), and the low SEL_W bits set `trig_edge_sel`.
- R5: Opcode 0x10 drives `dut_rst_n` low and keeps it low. Opcode 0x11 releases it.
- R6: Opcode 0x20 raises `arm_pulse` for exactly one cycle. In that same cycle the hold is cleared, so `dut_rst_n` is high while `arm_pulse` is high, even if it was held low the cycle before.
- R7: Opcode 0x21 raises `stop_pulse` for exactly one cycle and leaves the hold unchanged.
- R8: `dut_rst_n` is low whenever `cfg_rst_n` is low, whatever the hold state.
- R9: Opcode 0x30 makes the next byte on MISO the status value. Bit 0 is armed, bit 1 is triggered, bit 2 is done, and bits 7..3 are zero.
- R10: Opcode 0x40 streams buffer words starting at address 0. Each SAMP_W-bit word goes out as SAMP_W/8 bytes, most significant byte first. The address steps by one per word until chip select rises. `rd_data` is taken to be valid one cycle after `rd_addr` changes.
- R11: Chip select rising in the middle of a command drops any partial payload and leaves the targeted register unchanged. The next byte is decoded as an opcode.
- R12: After an unknown opcode, every further byte in the frame is ignored.
- R13: MISO is low while chip select is high, and all outputs hold their reset values after reset: `dut_rst_n` follows `cfg_rst_n`, and the strobes and trigger registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the unit |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| cfg_rst_n | input | 1 | Device post-configuration user reset, active low |
| dut_rst_n | output | 1 | Reset to observed design, active low |
| trig_pattern | output | VEC_W | Trigger comparison value |
| trig_mask | output | VEC_W | Trigger care mask |
| trig_edge_en | output | 1 | Edge trigger enable |
| trig_edge_rise | output | 1 | Edge polarity, 1 = rising |
| trig_edge_sel | output | SEL_W | Bit index watched for edges |
| arm_pulse | output | 1 | One-cycle start-acquisition strobe |
| stop_pulse | output | 1 | One-cycle stop-acquisition strobe |
| cap_armed | input | 1 | Capture controller is armed |
| cap_triggered | input | 1 | Capture controller has triggered |
| cap_done | input | 1 | Capture controller has finished |
| rd_addr | output | ADDR_W | Capture buffer read address |
| rd_data | input | SAMP_W | Capture buffer read word, one cycle after the address |

## Verification
Two events coincide by design: the arm strobe and the release of the reset hold. The bench provokes this by setting the hold in one frame and arming in the next. A monitor samples `dut_rst_n` in the cycle before `arm_pulse` and in the cycle `arm_pulse` is high, and expects low and then high; it also counts the strobe's high cycles. A second collision is checked as well: the device reset is pulled low while the hold is off, and the reset line must still fall.

// File: rtl/spi_dbg_pkg.sv
package spi_dbg_pkg;
    localparam logic [7:0] OP_PAT      = 8'h01;
    localparam logic [7:0] OP_MSK      = 8'h02;
    localparam logic [7:0] OP_EDGE     = 8'h03;
    localparam logic [7:0] OP_HOLD_ON  = 8'h10;
    localparam logic [7:0] OP_HOLD_OFF = 8'h11;
    localparam logic [7:0] OP_ARM      = 8'h20;
    localparam logic [7:0] OP_STOP     = 8'h21;
    localparam logic [7:0] OP_STAT     = 8'h30;
    localparam logic [7:0] OP_READ     = 8'h40;

    typedef enum logic [2:0] {
        ST_OPC, ST_PAT, ST_MSK, ST_EDGE, ST_STAT, ST_READ, ST_SKIP
    } dbg_state_t;
endpackage

// File: rtl/spi_dbg_sync.sv
module spi_dbg_sync #(
    parameter int             W      = 3,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= INIT;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= INIT;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_dbg_shift.sv
module spi_dbg_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic       cs_n_s,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       miso,
    output logic       cs_rise
);
    logic       sclk_d;
    logic       cs_d;
    logic [2:0] bitcnt;
    logic [7:0] rx_sr;
    logic [7:0] tx_sr;
    logic       sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_rise   = cs_n_s & ~cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            cs_d      <= 1'b1;
            bitcnt    <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            cs_d      <= cs_n_s;
            byte_done <= 1'b0;
            if (cs_n_s) begin
                bitcnt <= '0;
                tx_sr  <= '0;
            end else begin
                if (sclk_rise) begin
                    rx_sr  <= {rx_sr[6:0], mosi_s};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sr[6:0], mosi_s};
                        tx_sr     <= '0;
                    end
                end
                if (tx_load) tx_sr <= tx_byte;
            end
        end
    end

    // bit under the host's next rising edge
    assign miso = ~cs_n_s & tx_sr[3'd7 - bitcnt];
endmodule

// File: rtl/spi_dbg_ctrl.sv
module spi_dbg_ctrl
    import spi_dbg_pkg::*;
#(
    parameter int VEC_W  = 16,
    parameter int SAMP_W = 16,
    parameter int ADDR_W = 4,
    localparam int SEL_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              cfg_rst_n,
    output logic              dut_rst_n,
    output logic [VEC_W-1:0]  trig_pattern,
    output logic [VEC_W-1:0]  trig_mask,
    output logic              trig_edge_en,
    output logic              trig_edge_rise,
    output logic [SEL_W-1:0]  trig_edge_sel,
    output logic              arm_pulse,
    output logic              stop_pulse,
    input  logic              cap_armed,
    input  logic              cap_triggered,
    input  logic              cap_done,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [SAMP_W-1:0] rd_data
);
    localparam int VEC_BYTES  = (VEC_W + 7) / 8;
    localparam int SAMP_BYTES = SAMP_W / 8;
    localparam int STG_W      = VEC_BYTES * 8 + 8;
    localparam int PC_W       = $clog2(VEC_BYTES + 1);
    localparam int BIDX_W     = (SAMP_BYTES > 1) ? $clog2(SAMP_BYTES) : 1;

    logic [2:0]        sync_q;
    logic              sclk_s, mosi_s, cs_n_s;
    logic [7:0]        rx_byte, tx_byte;
    logic              byte_done, cs_rise, tx_load;
    dbg_state_t        state, nxt;
    logic [STG_W-1:0]  stage;
    logic [STG_W-1:0]  stage_nxt;
    logic [PC_W-1:0]   pay_cnt;
    logic [BIDX_W-1:0] bidx;
    logic [1:0]        ld_p;
    logic              hold;
    logic              last_pay;

    spi_dbg_sync #(.W(3), .STAGES(2), .INIT(3'b100)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .d   ({spi_cs_n, spi_sclk, spi_mosi}),
        .q   (sync_q)
    );
    assign {cs_n_s, sclk_s, mosi_s} = sync_q;

    spi_dbg_shift u_shift (
        .clk (clk), .rst_n (rst_n),
        .sclk_s (sclk_s), .mosi_s (mosi_s), .cs_n_s (cs_n_s),
        .tx_load (tx_load), .tx_byte (tx_byte),
        .rx_byte (rx_byte), .byte_done (byte_done),
        .miso (spi_miso), .cs_rise (cs_rise)
    );

    assign tx_load   = ld_p[1];
    assign stage_nxt = {stage[STG_W-9:0], rx_byte};
    assign last_pay  = (pay_cnt == PC_W'(VEC_BYTES - 1));
    assign dut_rst_n = cfg_rst_n & ~hold;

    always_comb begin
        tx_byte = 8'h00;
        if (state == ST_STAT)
            tx_byte = {5'b0, cap_done, cap_triggered, cap_armed};
        else if (state == ST_READ)
            tx_byte = rd_data[8*(SAMP_BYTES-1-int'(bidx)) +: 8];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPC;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_OPC;
        end else if (byte_done) begin
            unique case (state)
                ST_OPC: begin
                    case (rx_byte)
                        OP_PAT:  nxt = ST_PAT;
                        OP_MSK:  nxt = ST_MSK;
                        OP_EDGE: nxt = ST_EDGE;
                        OP_STAT: nxt = ST_STAT;
                        OP_READ: nxt = ST_READ;
                        OP_HOLD_ON, OP_HOLD_OFF, OP_ARM, OP_STOP: nxt = ST_OPC;
                        default: nxt = ST_SKIP;
                    endcase
                end
                ST_PAT, ST_MSK: if (last_pay) nxt = ST_OPC;
                ST_EDGE, ST_STAT: nxt = ST_OPC;
                ST_READ: nxt = ST_READ;
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_OPC;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_pattern   <= '0;
            trig_mask      <= '0;
            trig_edge_en   <= 1'b0;
            trig_edge_rise <= 1'b0;
            trig_edge_sel  <= '0;
            hold           <= 1'b0;
            arm_pulse      <= 1'b0;
            stop_pulse     <= 1'b0;
            rd_addr        <= '0;
            bidx           <= '0;
            pay_cnt        <= '0;
            stage          <= '0;
            ld_p           <= '0;
        end else begin
            arm_pulse  <= 1'b0;
            stop_pulse <= 1'b0;
            ld_p       <= {ld_p[0], 1'b0};
            if (cs_rise) begin
                pay_cnt <= '0;
            end else if (byte_done) begin
                unique case (state)
                    ST_OPC: begin
                        pay_cnt <= '0;
                        case (rx_byte)
                            OP_HOLD_ON:  hold <= 1'b1;
                            OP_HOLD_OFF: hold <= 1'b0;
                            OP_ARM: begin
                                arm_pulse <= 1'b1;
                                hold      <= 1'b0;
                            end
                            OP_STOP: stop_pulse <= 1'b1;
                            OP_STAT: ld_p[0] <= 1'b1;
                            OP_READ: begin
                                rd_addr <= '0;
                                bidx    <= '0;
                                ld_p[0] <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    ST_PAT, ST_MSK: begin
                        stage   <= stage_nxt;
                        pay_cnt <= pay_cnt + 1'b1;
                        if (last_pay) begin
                            if (state == ST_PAT) trig_pattern <= stage_nxt[VEC_W-1:0];
                            else                 trig_mask    <= stage_nxt[VEC_W-1:0];
                        end
                    end
                    ST_EDGE: begin
                        trig_edge_en   <= rx_byte[7];
                        trig_edge_rise <= rx_byte[6];
                        trig_edge_sel  <= rx_byte[SEL_W-1:0];
                    end
                    ST_READ: begin
                        if (bidx == BIDX_W'(SAMP_BYTES - 1)) begin
                            bidx    <= '0;
                            rd_addr <= rd_addr + 1'b1;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                        ld_p[0] <= 1'b1;
                    end
                    ST_STAT, ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_dbg_chk.sv
module spi_dbg_chk
    import spi_dbg_pkg::*;
#(
    parameter int VEC_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_rst_n,
    input logic              dut_rst_n,
    input logic              arm_pulse,
    input logic              stop_pulse,
    input logic              byte_done,
    input dbg_state_t        state,
    input logic [VEC_W-1:0]  trig_pattern,
    input logic [VEC_W-1:0]  trig_mask,
    input logic [ADDR_W-1:0] rd_addr
);
    p_arm_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pulse |=> !arm_pulse);

    p_arm_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_pulse && cfg_rst_n) |-> dut_rst_n);

    p_stop_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    p_hold_needs_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dut_rst_n) && cfg_rst_n && $past(cfg_rst_n)) |-> $past(byte_done && state == ST_OPC));

    p_pattern_on_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trig_pattern) |-> $past(byte_done && state == ST_PAT));

    p_mask_on_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trig_mask) |-> $past(byte_done && state == ST_MSK));

    p_addr_on_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr) |-> $past(byte_done));
endmodule

bind spi_dbg_ctrl spi_dbg_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .cfg_rst_n (cfg_rst_n), .dut_rst_n (dut_rst_n),
    .arm_pulse (arm_pulse), .stop_pulse (stop_pulse), .byte_done (byte_done),
    .state (state), .trig_pattern (trig_pattern), .trig_mask (trig_mask),
    .rd_addr (rd_addr)
);

// File: tb/sim_spi_dbg_ctrl.sv
module sim_spi_dbg_ctrl;
    localparam int VEC_W  = 16;
    localparam int SAMP_W = 16;
    localparam int ADDR_W = 4;
    localparam int SEL_W  = $clog2(VEC_W);
    localparam int HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic cfg_rst_n = 1'b1;
    logic dut_rst_n;
    logic [VEC_W-1:0] trig_pattern, trig_mask;
    logic trig_edge_en, trig_edge_rise;
    logic [SEL_W-1:0] trig_edge_sel;
    logic arm_pulse, stop_pulse;
    logic cap_armed = 1'b0, cap_triggered = 1'b0, cap_done = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic [SAMP_W-1:0] rd_data = '0;

    always #2 clk = ~clk;

    spi_dbg_ctrl #(.VEC_W(VEC_W), .SAMP_W(SAMP_W), .ADDR_W(ADDR_W)) u0 (.*);

    function automatic logic [SAMP_W-1:0] samp(input logic [ADDR_W-1:0] a);
        return 16'h2040 + 16'h0111 * SAMP_W'(a);
    endfunction
    always @(posedge clk) rd_data <= samp(rd_addr);

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe monitor
    int arm_hi = 0, stop_hi = 0;
    logic prev_rst = 1'b1, rst_at_arm = 1'b0, rst_before_arm = 1'b1;
    always @(negedge clk) begin
        if (arm_pulse) begin
            arm_hi++;
            rst_at_arm     = dut_rst_n;
            rst_before_arm = prev_rst;
        end
        if (stop_pulse) stop_hi++;
        prev_rst = dut_rst_n;
    end

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_q[$];
    initial forever begin
        @(negedge clk);
        if (rx_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = rx_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(a == e, t, 32'(a), 32'(e));
        end
    end

    task automatic frame_start();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string tag);
        logic [7:0] r;
        if (chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            r[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        if (chk) rx_q.push_back(r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        frame_start(); xfer(op, 0, 0, ""); frame_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R13 reset state
        check(trig_pattern == 0 && trig_mask == 0, "R13 trig regs", 32'(trig_pattern), 0);
        check(dut_rst_n == 1 && arm_pulse == 0 && stop_pulse == 0, "R13 reset outputs", 32'({dut_rst_n, arm_pulse, stop_pulse}), 32'h4);
        check(spi_miso == 0, "R13 miso idle", 32'(spi_miso), 0);

        // R1 R2 pattern write
        frame_start(); xfer(8'h01, 0, 0, ""); xfer(8'hA5, 0, 0, ""); xfer(8'hC3, 0, 0, ""); frame_end();
        check(trig_pattern == 16'hA5C3, "R1 R2 pattern", 32'(trig_pattern), 32'hA5C3);

        // R3 mask write
        frame_start(); xfer(8'h02, 0, 0, ""); xfer(8'h0F, 0, 0, ""); xfer(8'hF0, 0, 0, ""); frame_end();
        check(trig_mask == 16'h0FF0, "R3 mask", 32'(trig_mask), 32'h0FF0);

        // R11 abort mid payload
        frame_start(); xfer(8'h01, 0, 0, ""); xfer(8'h11, 0, 0, ""); frame_end();
        check(trig_pattern == 16'hA5C3, "R11 aborted pattern kept", 32'(trig_pattern), 32'hA5C3);
        frame_start(); xfer(8'h02, 0, 0, ""); xfer(8'h12, 0, 0, ""); xfer(8'h34, 0, 0, ""); frame_end();
        check(trig_mask == 16'h1234, "R11 opcode after abort", 32'(trig_mask), 32'h1234);

        // R4 edge select
        frame_start(); xfer(8'h03, 0, 0, ""); xfer(8'hC5, 0, 0, ""); frame_end();
        check({trig_edge_en, trig_edge_rise, trig_edge_sel} == {1'b1, 1'b1, 4'd5}, "R4 edge rising",
              32'({trig_edge_en, trig_edge_rise, trig_edge_sel}), 32'h35);
        frame_start(); xfer(8'h03, 0, 0, ""); xfer(8'h83, 0, 0, ""); frame_end();
        check({trig_edge_en, trig_edge_rise, trig_edge_sel} == {1'b1, 1'b0, 4'd3}, "R4 edge falling",
              32'({trig_edge_en, trig_edge_rise, trig_edge_sel}), 32'h23);

        // R5 hold on/off
        cmd1(8'h10);
        check(dut_rst_n == 0, "R5 hold on", 32'(dut_rst_n), 0);
        cmd1(8'h11);
        check(dut_rst_n == 1, "R5 hold off", 32'(dut_rst_n), 1);

        // R8 device reset passes through
        cfg_rst_n = 1'b0;
        @(negedge clk);
        check(dut_rst_n == 0, "R8 cfg reset", 32'(dut_rst_n), 0);
        cfg_rst_n = 1'b1;
        @(negedge clk);

        // R6 arm releases hold in same cycle
        cmd1(8'h10);
        check(dut_rst_n == 0, "R6 held before arm", 32'(dut_rst_n), 0);
        cmd1(8'h20);
        check(arm_hi == 1, "R6 arm width", 32'(arm_hi), 1);
        check(rst_before_arm == 0 && rst_at_arm == 1, "R6 release with strobe",
              32'({rst_before_arm, rst_at_arm}), 32'h1);
        check(dut_rst_n == 1, "R6 released after arm", 32'(dut_rst_n), 1);

        // R7 stop
        cmd1(8'h10);
        cmd1(8'h21);
        check(stop_hi == 1, "R7 stop width", 32'(stop_hi), 1);
        check(dut_rst_n == 0, "R7 hold unchanged", 32'(dut_rst_n), 0);
        cmd1(8'h11);

        // R9 status
        cap_armed = 1; cap_triggered = 0; cap_done = 1;
        frame_start(); xfer(8'h30, 0, 0, ""); xfer(8'h00, 1, 8'h05, "R9 status 05"); frame_end();
        cap_armed = 0; cap_triggered = 1; cap_done = 0;
        frame_start(); xfer(8'h30, 0, 0, ""); xfer(8'h00, 1, 8'h02, "R9 status 02"); frame_end();

        // R10 sample stream
        frame_start();
        xfer(8'h40, 0, 0, "");
        for (int a = 0; a < 3; a++) begin
            logic [SAMP_W-1:0] w;
            w = samp(ADDR_W'(a));
            xfer(8'h00, 1, w[15:8], "R10 read hi");
            xfer(8'h00, 1, w[7:0],  "R10 read lo");
        end
        frame_end();

        // R12 unknown opcode swallows the rest
        frame_start(); xfer(8'h7E, 0, 0, ""); xfer(8'h20, 0, 0, ""); xfer(8'h10, 0, 0, ""); frame_end();
        check(arm_hi == 1, "R12 no arm", 32'(arm_hi), 1);
        check(dut_rst_n == 1, "R12 no hold", 32'(dut_rst_n), 1);
        check(spi_miso == 0, "R13 miso idle after frames", 32'(spi_miso), 0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R10 scoreboard drained", 32'(exp_q.size()), 0);
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule